// File: doc/BRIEF.md
# Inter-Processor Flag Handshake Unit

This block links two processor subsystems, called side A (the master) and side B (the controller), through two mirrored sets of 32 one-bit signalling channels. Each side sends on its own outgoing channels and receives on the other side's. A sender raises a channel by writing a one to its set register. The receiver sees that channel in its status register and releases it by writing a one to its acknowledge register. The sender may also withdraw a channel that is still pending. The sender can read its own outgoing flags back. Each direction also has a command word and a data-address word. The sender writes them and the receiver reads them, so that a request can be decoded when its channel fires.

Only the four lowest channels of each direction drive a level interrupt line into the receiving side. The other channels have to be polled through the status register. A flag stays pending until the receiver acknowledges it or the sender cancels it.

Both sides reach the block through the same small register port: a 4-bit word offset, a write strobe and 32-bit write data. The read data is registered and shows the register selected in the previous cycle.

Top module: `ipc_flag_hub`

## Requirements
- R1: After a synchronous active-high reset, every outgoing flag, status bit, command word, data-address word and interrupt line of both directions is 0.
- R2: Writing data with bit i = 1 to offset 0x0 (set) makes channel i pending. From the next cycle the bit reads as 1 at the sender's offset 0x2 (flag readback) and at the receiver's offset 0x3 (status). Zero bits in the written data leave their channels unchanged.
- R3: Interrupt line i (i = 0..3) into the receiving side is high exactly while channel i of that direction is pending. It goes high in the cycle after the edge on which the set write is taken.
- R4: Channels 4..31 never change any interrupt line; they are seen only by polling offset 0x3.
- R5: The receiver writing data with bit i = 1 to offset 0x4 (acknowledge) clears pending channel i and its interrupt line. Zero bits have no effect.
- R6: The sender writing data with bit i = 1 to offset 0x1 (clear) cancels pending channel i before it is acknowledged. Zero bits have no effect.
- R7: When a set on bit i from the sender and an acknowledge on bit i from the receiver are taken on the same edge, channel i ends pending.
- R8: Reads of offsets 0x0, 0x1, 0x4 and of any offset from 0x9 to 0xF return 0.
- R9: The sender's command word (offset 0x5) and data-address word (offset 0x6) read back at the same offsets on the sender and at offsets 0x7 and 0x8 on the receiver.
- R10: The two directions are independent. Side B's writes at offsets 0x0, 0x1, 0x5 and 0x6 act only on the B-to-A direction, and side A acknowledges that direction at its offset 0x4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_addr | input | 4 | Side A register word offset |
| a_we | input | 1 | Side A write strobe |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A registered read data |
| a_irq | output | 4 | Interrupts into side A from B-to-A channels 0..3 |
| b_addr | input | 4 | Side B register word offset |
| b_we | input | 1 | Side B write strobe |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B registered read data |
| b_irq | output | 4 | Interrupts into side B from A-to-B channels 0..3 |

## Verification
A corrupted flag bit shows up on the next read of the receiver's status register or the sender's flag readback, one cycle after the read offset is presented. For the four low channels it shows even sooner: the interrupt line is wrong in the very cycle after the faulty edge. The bench therefore compares both interrupt vectors after every write and reads status and flag registers often during random traffic. A wrong priority between set and acknowledge, or between the two directions, would leave a stale or missing bit. That bit persists until the next release, so a later poll exposes it.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  localparam int REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    OFF_SET   = 4'd0,
    OFF_CLR   = 4'd1,
    OFF_FLG   = 4'd2,
    OFF_STS   = 4'd3,
    OFF_ACK   = 4'd4,
    OFF_CMD   = 4'd5,
    OFF_DADR  = 4'd6,
    OFF_RCMD  = 4'd7,
    OFF_RDADR = 4'd8
  } reg_off_e;
endpackage

// File: rtl/ipc_chan_dir.sv
module ipc_chan_dir #(
  parameter int NCH  = 32,
  parameter int NIRQ = 4,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCH-1:0]  set_req,
  input  logic [NCH-1:0]  clr_req,
  input  logic [NCH-1:0]  ack_req,
  input  logic            cmd_we,
  input  logic            dadr_we,
  input  logic [DW-1:0]   wdata,
  output logic [NCH-1:0]  flag,
  output logic [NIRQ-1:0] irq,
  output logic [DW-1:0]   cmd,
  output logic [DW-1:0]   dadr
);
  // one flop per channel; a set outranks any release in the same cycle
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)
        flag[ch] <= 1'b0;
      else if (set_req[ch])
        flag[ch] <= 1'b1;
      else if (clr_req[ch] || ack_req[ch])
        flag[ch] <= 1'b0;
    end
  end

  // level interrupts come straight from the channel flops
  for (genvar q = 0; q < NIRQ; q++) begin : g_irq
    assign irq[q] = flag[q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd  <= '0;
      dadr <= '0;
    end else begin
      if (cmd_we)  cmd  <= wdata;
      if (dadr_we) dadr <= wdata;
    end
  end
endmodule

// File: rtl/ipc_side_port.sv
module ipc_side_port
  import ipc_pkg::*;
#(
  parameter int NCH = 32,
  parameter int DW  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] addr,
  input  logic              we,
  input  logic [DW-1:0]     wdata,
  output logic [NCH-1:0]    set_req,
  output logic [NCH-1:0]    clr_req,
  output logic [NCH-1:0]    ack_req,
  output logic              cmd_we,
  output logic              dadr_we,
  input  logic [NCH-1:0]    out_flag,
  input  logic [NCH-1:0]    in_flag,
  input  logic [DW-1:0]     out_cmd,
  input  logic [DW-1:0]     out_dadr,
  input  logic [DW-1:0]     in_cmd,
  input  logic [DW-1:0]     in_dadr,
  output logic [DW-1:0]     rdata
);
  logic          live_we;
  logic [DW-1:0] out_flag_x;
  logic [DW-1:0] in_flag_x;
  logic [DW-1:0] rd_mux;

  assign live_we = we & ~rst;

  // write decode: strobes carry the written bits so zeros do nothing
  always_comb begin
    set_req = '0;
    clr_req = '0;
    ack_req = '0;
    cmd_we  = 1'b0;
    dadr_we = 1'b0;
    if (live_we) begin
      case (addr)
        OFF_SET:  set_req = wdata[NCH-1:0];
        OFF_CLR:  clr_req = wdata[NCH-1:0];
        OFF_ACK:  ack_req = wdata[NCH-1:0];
        OFF_CMD:  cmd_we  = 1'b1;
        OFF_DADR: dadr_we = 1'b1;
        default:  ;
      endcase
    end
  end

  always_comb begin
    out_flag_x = '0;
    in_flag_x  = '0;
    out_flag_x[NCH-1:0] = out_flag;
    in_flag_x[NCH-1:0]  = in_flag;
  end

  always_comb begin
    case (addr)
      OFF_FLG:   rd_mux = out_flag_x;
      OFF_STS:   rd_mux = in_flag_x;
      OFF_CMD:   rd_mux = out_cmd;
      OFF_DADR:  rd_mux = out_dadr;
      OFF_RCMD:  rd_mux = in_cmd;
      OFF_RDADR: rd_mux = in_dadr;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/ipc_flag_hub.sv
module ipc_flag_hub
  import ipc_pkg::*;
#(
  parameter int NCH  = 32,
  parameter int NIRQ = 4,
  parameter int DW   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] a_addr,
  input  logic              a_we,
  input  logic [DW-1:0]     a_wdata,
  output logic [DW-1:0]     a_rdata,
  output logic [NIRQ-1:0]   a_irq,
  input  logic [REG_AW-1:0] b_addr,
  input  logic              b_we,
  input  logic [DW-1:0]     b_wdata,
  output logic [DW-1:0]     b_rdata,
  output logic [NIRQ-1:0]   b_irq
);
  // a2b: side A sends, side B receives; b2a mirrors it
  logic [NCH-1:0] a_set, a_clr, a_ack, b_set, b_clr, b_ack;
  logic           a_cmd_we, a_dadr_we, b_cmd_we, b_dadr_we;
  logic [NCH-1:0] a2b_flag, b2a_flag;
  logic [DW-1:0]  a2b_cmd, a2b_dadr, b2a_cmd, b2a_dadr;

  ipc_side_port #(.NCH(NCH), .DW(DW)) u_port_a (
    .clk(clk), .rst(rst), .addr(a_addr), .we(a_we), .wdata(a_wdata),
    .set_req(a_set), .clr_req(a_clr), .ack_req(a_ack),
    .cmd_we(a_cmd_we), .dadr_we(a_dadr_we),
    .out_flag(a2b_flag), .in_flag(b2a_flag),
    .out_cmd(a2b_cmd), .out_dadr(a2b_dadr),
    .in_cmd(b2a_cmd), .in_dadr(b2a_dadr),
    .rdata(a_rdata)
  );

  ipc_side_port #(.NCH(NCH), .DW(DW)) u_port_b (
    .clk(clk), .rst(rst), .addr(b_addr), .we(b_we), .wdata(b_wdata),
    .set_req(b_set), .clr_req(b_clr), .ack_req(b_ack),
    .cmd_we(b_cmd_we), .dadr_we(b_dadr_we),
    .out_flag(b2a_flag), .in_flag(a2b_flag),
    .out_cmd(b2a_cmd), .out_dadr(b2a_dadr),
    .in_cmd(a2b_cmd), .in_dadr(a2b_dadr),
    .rdata(b_rdata)
  );

  ipc_chan_dir #(.NCH(NCH), .NIRQ(NIRQ), .DW(DW)) u_a2b (
    .clk(clk), .rst(rst),
    .set_req(a_set), .clr_req(a_clr), .ack_req(b_ack),
    .cmd_we(a_cmd_we), .dadr_we(a_dadr_we), .wdata(a_wdata),
    .flag(a2b_flag), .irq(b_irq), .cmd(a2b_cmd), .dadr(a2b_dadr)
  );

  ipc_chan_dir #(.NCH(NCH), .NIRQ(NIRQ), .DW(DW)) u_b2a (
    .clk(clk), .rst(rst),
    .set_req(b_set), .clr_req(b_clr), .ack_req(a_ack),
    .cmd_we(b_cmd_we), .dadr_we(b_dadr_we), .wdata(b_wdata),
    .flag(b2a_flag), .irq(a_irq), .cmd(b2a_cmd), .dadr(b2a_dadr)
  );
endmodule

// File: rtl/ipc_flag_hub_chk.sv
module ipc_flag_hub_chk
  import ipc_pkg::*;
#(
  parameter int NCH  = 32,
  parameter int NIRQ = 4,
  parameter int DW   = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [REG_AW-1:0] a_addr,
  input logic              a_we,
  input logic [DW-1:0]     a_wdata,
  input logic [DW-1:0]     a_rdata,
  input logic [REG_AW-1:0] b_addr,
  input logic              b_we,
  input logic [DW-1:0]     b_wdata,
  input logic [NIRQ-1:0]   b_irq,
  input logic [NCH-1:0]    a2b_flag
);
  logic a_setw, b_ackw;
  assign a_setw = a_we && (a_addr == OFF_SET);
  assign b_ackw = b_we && (b_addr == OFF_ACK);

  // R2
  set_makes_pending_chk: assert property (@(posedge clk) disable iff (rst)
    a_setw |=> ((a2b_flag & $past(a_wdata[NCH-1:0])) == $past(a_wdata[NCH-1:0])));

  // R5
  ack_releases_chk: assert property (@(posedge clk) disable iff (rst)
    (b_ackw && !a_setw) |=> ((a2b_flag & $past(b_wdata[NCH-1:0])) == '0));

  // R7
  set_beats_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (a_setw && b_ackw) |=>
      ((a2b_flag & $past(a_wdata[NCH-1:0] & b_wdata[NCH-1:0])) ==
       $past(a_wdata[NCH-1:0] & b_wdata[NCH-1:0])));

  // R8
  set_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (a_addr == OFF_SET) |=> (a_rdata == '0));

  for (genvar q = 0; q < NIRQ; q++) begin : g_irq_chk
    // R3
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(b_irq[q]) |-> $past(a_setw && a_wdata[q]));
  end
endmodule

bind ipc_flag_hub ipc_flag_hub_chk #(.NCH(NCH), .NIRQ(NIRQ), .DW(DW)) u_chk (
  .clk(clk), .rst(rst),
  .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata), .a_rdata(a_rdata),
  .b_addr(b_addr), .b_we(b_we), .b_wdata(b_wdata), .b_irq(b_irq),
  .a2b_flag(a2b_flag)
);

// File: tb/ipc_flag_hub_tb.sv
module ipc_flag_hub_tb;
  import ipc_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  a_addr = '0, b_addr = '0;
  logic        a_we = 1'b0, b_we = 1'b0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic [31:0] a_rdata, b_rdata;
  logic [3:0]  a_irq, b_irq;

  int total = 0, fails = 0;
  bit done = 1'b0;

  // reference model
  logic [31:0] m_a2b = '0, m_b2a = '0;
  logic [31:0] m_acmd = '0, m_adadr = '0, m_bcmd = '0, m_bdadr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipc_flag_hub u_dut (
    .clk(clk), .rst(rst),
    .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_irq(a_irq),
    .b_addr(b_addr), .b_we(b_we), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_irq(b_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_read(input bit side_b, input logic [3:0] off);
    case (off)
      OFF_FLG:   return side_b ? m_b2a : m_a2b;
      OFF_STS:   return side_b ? m_a2b : m_b2a;
      OFF_CMD:   return side_b ? m_bcmd : m_acmd;
      OFF_DADR:  return side_b ? m_bdadr : m_adadr;
      OFF_RCMD:  return side_b ? m_acmd : m_bcmd;
      OFF_RDADR: return side_b ? m_adadr : m_bdadr;
      default:   return 32'h0;
    endcase
  endfunction

  function automatic void model_write(input bit side_b, input logic [3:0] off, input logic [31:0] d);
    case (off)
      OFF_SET:  if (side_b) m_b2a |= d; else m_a2b |= d;
      OFF_CLR:  if (side_b) m_b2a &= ~d; else m_a2b &= ~d;
      OFF_ACK:  if (side_b) m_a2b &= ~d; else m_b2a &= ~d;
      OFF_CMD:  if (side_b) m_bcmd = d; else m_acmd = d;
      OFF_DADR: if (side_b) m_bdadr = d; else m_adadr = d;
      default: ;
    endcase
  endfunction

  task automatic check_irqs(input string req);
    check(req, {28'h0, a_irq}, {28'h0, m_b2a[3:0]});
    check(req, {28'h0, b_irq}, {28'h0, m_a2b[3:0]});
  endtask

  task automatic wr(input bit side_b, input logic [3:0] off, input logic [31:0] d);
    @(negedge clk);
    if (side_b) begin b_addr = off; b_we = 1'b1; b_wdata = d; end
    else        begin a_addr = off; a_we = 1'b1; a_wdata = d; end
    @(posedge clk);
    #1;
    a_we = 1'b0; b_we = 1'b0;
    model_write(side_b, off, d);
  endtask

  // same edge: A writes at a_off, B writes at b_off
  task automatic wr_both(input logic [3:0] a_off, input logic [31:0] ad,
                         input logic [3:0] b_off, input logic [31:0] bd);
    @(negedge clk);
    a_addr = a_off; a_we = 1'b1; a_wdata = ad;
    b_addr = b_off; b_we = 1'b1; b_wdata = bd;
    @(posedge clk);
    #1;
    a_we = 1'b0; b_we = 1'b0;
    // set has priority: apply releases first, then sets
    if (a_off != OFF_SET) model_write(1'b0, a_off, ad);
    if (b_off != OFF_SET) model_write(1'b1, b_off, bd);
    if (a_off == OFF_SET) model_write(1'b0, a_off, ad);
    if (b_off == OFF_SET) model_write(1'b1, b_off, bd);
  endtask

  task automatic rd(input bit side_b, input logic [3:0] off, input string req);
    @(negedge clk);
    if (side_b) b_addr = off; else a_addr = off;
    @(posedge clk);
    #1;
    check(req, side_b ? b_rdata : a_rdata, expect_read(side_b, off));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset state
    check_irqs("R1");
    rd(1'b0, OFF_STS, "R1"); rd(1'b1, OFF_STS, "R1");
    rd(1'b0, OFF_FLG, "R1"); rd(1'b1, OFF_RCMD, "R1"); rd(1'b0, OFF_RDADR, "R1");

    // R2/R3: set channels 0 and 5
    wr(1'b0, OFF_SET, 32'h0000_0021);
    check("R3", {28'h0, b_irq}, 32'h1);
    rd(1'b1, OFF_STS, "R2"); rd(1'b0, OFF_FLG, "R2");
    rd(1'b0, OFF_STS, "R10");
    wr(1'b0, OFF_SET, 32'h0);
    rd(1'b1, OFF_STS, "R2");

    // R4: high channel leaves interrupts alone
    wr(1'b0, OFF_SET, 32'h0001_0000);
    check("R4", {28'h0, b_irq}, 32'h1);
    rd(1'b1, OFF_STS, "R4");
    wr(1'b0, OFF_SET, 32'hFFFF_FFF0);
    check("R4", {28'h0, b_irq}, 32'h1);
    check("R4", {28'h0, a_irq}, 32'h0);
    wr(1'b1, OFF_ACK, 32'hFFFE_FFC0);
    check("R4", {28'h0, b_irq}, 32'h1);

    // R5: acknowledge
    wr(1'b1, OFF_ACK, 32'h0000_0001);
    check("R5", {28'h0, b_irq}, 32'h0);
    rd(1'b1, OFF_STS, "R5");
    wr(1'b1, OFF_ACK, 32'h0);
    rd(1'b1, OFF_STS, "R5");

    // R6: sender cancel
    wr(1'b0, OFF_CLR, 32'h0000_0020);
    rd(1'b1, OFF_STS, "R6");
    wr(1'b0, OFF_CLR, 32'h0);
    rd(1'b0, OFF_FLG, "R6");

    // R7: set and acknowledge on the same edge
    wr_both(OFF_SET, 32'h0000_0004, OFF_ACK, 32'h0000_0004);
    check("R7", {28'h0, b_irq}, 32'h4);
    check("R7", m_a2b & 32'h4, 32'h4);
    wr_both(OFF_SET, 32'h0001_0004, OFF_ACK, 32'h0001_0004);
    rd(1'b1, OFF_STS, "R7");

    // R8: write-only and unused offsets read 0
    rd(1'b0, OFF_SET, "R8"); rd(1'b0, OFF_CLR, "R8"); rd(1'b1, OFF_ACK, "R8");
    rd(1'b1, 4'hF, "R8"); rd(1'b0, 4'h9, "R8");

    // R9: command and data-address words
    wr(1'b0, OFF_CMD, 32'hDEAD_BEEF);
    wr(1'b0, OFF_DADR, 32'h0000_1234);
    rd(1'b1, OFF_RCMD, "R9"); rd(1'b1, OFF_RDADR, "R9");
    rd(1'b0, OFF_CMD, "R9"); rd(1'b0, OFF_DADR, "R9");

    // R10: mirrored direction
    wr(1'b1, OFF_SET, 32'hF000_0003);
    check("R10", {28'h0, a_irq}, 32'h3);
    rd(1'b0, OFF_STS, "R10"); rd(1'b1, OFF_FLG, "R10");
    wr(1'b1, OFF_CMD, 32'h5A5A_0001);
    rd(1'b0, OFF_RCMD, "R10"); rd(1'b1, OFF_RCMD, "R10");
    wr(1'b0, OFF_ACK, 32'h0000_0001);
    check("R10", {28'h0, a_irq}, 32'h2);
    rd(1'b1, OFF_STS, "R10");

    // random traffic
    for (int it = 0; it < 400; it++) begin
      logic [31:0] d;
      logic [3:0]  off;
      bit          sb;
      sb = 1'($urandom);
      case ($urandom % 5)
        0: off = OFF_SET;
        1: off = OFF_CLR;
        2: off = OFF_ACK;
        3: off = OFF_CMD;
        default: off = OFF_DADR;
      endcase
      d = ($urandom % 2) ? ($urandom & 32'h0000_000F) : $urandom;
      if ($urandom % 6 == 0)
        wr_both(OFF_SET, d, OFF_ACK, d | 32'h1);
      else
        wr(sb, off, d);
      check_irqs("R3 random");
      rd(1'($urandom), 4'($urandom % 10), "R2 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule